// File: doc/BRIEF.md
# Internal Scratchpad and Special-Register Access Unit

This block is the internal data memory of a small 8-bit controller datapath. It holds 128 bytes of scratchpad RAM along with a handful of special registers: an accumulator, a second operand register, a stack pointer and a status register. The status register carries the working-register bank select. One 8-bit address space covers all of this storage. The lower half is RAM. Within the RAM, the first 32 bytes serve as four banks of eight working registers, and a 16-byte window can be reached one bit at a time. The upper half of the address space selects special registers.

Each cycle the datapath presents a mode, an address or register number, write data, a bit value and read/write strobes. The unit resolves the operand location and returns the byte or bit combinationally. It commits a write at the next rising clock edge. In indirect mode the pointer is fetched from working register 0 or 1 of the current bank. An illegal pointer register raises a flag. A pointer that leaves the RAM also raises a flag and is blocked. Push and pop use the stack pointer and take their operand by direct address.

Top module: `iram_access_unit`

## Requirements
- R1: After a synchronous active-low reset, the stack pointer (direct address 81h) reads 07h. The accumulator (E0h), the second operand register (F0h) and the status register (D0h) all read 00h.
- R2: Mode code 0 is register mode. Register n (addr_i[2:0]) maps to RAM byte bank*8+n. The bank is bits 4:3 of the status register at D0h.
- R3: Mode code 1 is direct mode. An address below 80h selects that RAM byte. Register and direct views of the same byte alias, so R4 in bank 0 is byte 04h.
- R4: A direct address of 80h or above selects a special register: 81h stack pointer, D0h status, E0h accumulator, F0h second operand. Any other such address reads 00h and ignores writes.
- R5: Mode code 2 is indirect mode. addr_i[0] selects R0 or R1 of the current bank, and that register's value is the RAM address used for the read or write.
- R6: In indirect mode, a register number of 2 to 7 raises err_ptr_o. The read returns 00h and a write is ignored.
- R7: In indirect mode, a pointer value of 80h or above raises err_range_o. The read returns 00h and a write is ignored, so no special register changes.
- R8: Mode code 3 is bit mode. Bit address b below 80h selects bit b&7 of byte 20h+(b>>3). rbit_o returns that bit and rdata_o reads 00h. A write changes only that bit. A bit address of 80h or above raises err_range_o, returns 0 and ignores writes.
- R9: Mode code 4 is push. On a write strobe, the stack pointer increments and the byte at direct address addr_i is stored at RAM[new stack pointer].
- R10: Mode code 5 is pop. While rd_i is high, rdata_o shows RAM[stack pointer]. On a write strobe, that byte is stored at direct address addr_i and the stack pointer decrements.
- R11: Read data is combinational in the same cycle and writes commit on the rising edge. With rd_i low, rdata_o is 00h and rbit_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Access mode code |
| addr_i | input | 8 | Direct address, register number or bit address |
| wdata_i | input | 8 | Byte write data |
| bit_i | input | 1 | Bit write value |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read byte |
| rbit_o | output | 1 | Read bit |
| err_ptr_o | output | 1 | Illegal indirect pointer register |
| err_range_o | output | 1 | Indirect pointer or bit address out of range |

## Verification
A wrong bank field or a wrong stack pointer cannot be seen in the cycle it goes wrong. It shows up at the next register-mode, indirect or stack access, which reaches a different RAM byte. It can also be read directly at D0h or 81h in the cycle after the write. A lost bit merge corrupts the seven neighbouring bits of the byte and appears on the next direct read of it. A blocked indirect write that leaks through appears as a changed byte or special register on the following read. The scoreboard therefore follows each write with a read of the location it should have changed and of the location it must not have changed.

// File: rtl/iram_pkg.sv
// Shared constants and types for the internal data memory access unit.
// Assumes an 8-bit address space whose lower half is RAM.
package iram_pkg;
    localparam int unsigned DW         = 8;
    localparam int unsigned BIT_SPACE  = 128;

    typedef enum logic [2:0] {
        MODE_REG  = 3'd0,
        MODE_DIR  = 3'd1,
        MODE_IND  = 3'd2,
        MODE_BIT  = 3'd3,
        MODE_PUSH = 3'd4,
        MODE_POP  = 3'd5
    } acc_mode_e;

    localparam logic [7:0] SFR_SP      = 8'h81;
    localparam logic [7:0] SFR_STAT    = 8'hD0;
    localparam logic [7:0] SFR_ACC     = 8'hE0;
    localparam logic [7:0] SFR_B       = 8'hF0;
    localparam logic [7:0] SP_RESET    = 8'h07;
    localparam logic [7:0] BITWIN_BASE = 8'h20;

    typedef struct packed {
        logic       to_ram;
        logic       to_sfr;
        logic [7:0] idx;
        logic [2:0] bpos;
        logic       err_ptr;
        logic       err_range;
    } target_t;
endpackage

// File: rtl/iram_addr_resolve.sv
// Operand location resolver. Purely combinational: it turns mode, address,
// current bank and the fetched pointer value into a RAM or special-register
// target and error flags. Assumes the pointer register value is provided by
// the caller from the index given on ptr_idx_o.
module iram_addr_resolve
    import iram_pkg::*;
#(
    parameter int unsigned RAM_DEPTH     = 128,
    parameter int unsigned REGS_PER_BANK = 8
) (
    input  logic [2:0]                   mode_i,
    input  logic [7:0]                   addr_i,
    input  logic [1:0]                   bank_i,
    input  logic [7:0]                   ptr_val_i,
    output logic [$clog2(RAM_DEPTH)-1:0] ptr_idx_o,
    output target_t                      tgt_o
);
    localparam int unsigned AW = $clog2(RAM_DEPTH);
    localparam int unsigned RW = $clog2(REGS_PER_BANK);

    acc_mode_e mode;
    assign mode = acc_mode_e'(mode_i);

    // Pointer register (R0 or R1) of the current bank.
    assign ptr_idx_o = AW'(int'(bank_i) * REGS_PER_BANK + int'(addr_i[0]));

    // Select target and flag errors for the requested mode.
    always_comb begin
        tgt_o = '0;
        case (mode)
            MODE_REG: begin
                tgt_o.to_ram = 1'b1;
                tgt_o.idx    = 8'(int'(bank_i) * REGS_PER_BANK + int'(addr_i[RW-1:0]));
            end
            MODE_DIR, MODE_PUSH, MODE_POP: begin
                tgt_o.idx = addr_i;
                if (int'(addr_i) < RAM_DEPTH) tgt_o.to_ram = 1'b1;
                else                          tgt_o.to_sfr = 1'b1;
            end
            MODE_IND: begin
                if (addr_i[RW-1:1] != '0) begin
                    tgt_o.err_ptr = 1'b1;
                end else if (int'(ptr_val_i) >= RAM_DEPTH) begin
                    tgt_o.err_range = 1'b1;
                end else begin
                    tgt_o.to_ram = 1'b1;
                    tgt_o.idx    = ptr_val_i;
                end
            end
            MODE_BIT: begin
                if (int'(addr_i) >= BIT_SPACE) begin
                    tgt_o.err_range = 1'b1;
                end else begin
                    tgt_o.to_ram = 1'b1;
                    tgt_o.idx    = BITWIN_BASE + {3'b000, addr_i[7:3]};
                    tgt_o.bpos   = addr_i[2:0];
                end
            end
            default: tgt_o = '0;
        endcase
    end
endmodule

// File: rtl/iram_ram.sv
// Scratchpad RAM with three asynchronous read ports and one synchronous
// write port. Contents are not reset; software initialises what it uses.
module iram_ram #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [DW-1:0] rdata_b_o,
    input  logic [AW-1:0] raddr_c_i,
    output logic [DW-1:0] rdata_c_o
);
    logic [DW-1:0] mem [DEPTH];

    // Commit one byte per cycle.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem[raddr_a_i];
    assign rdata_b_o = mem[raddr_b_i];
    assign rdata_c_o = mem[raddr_c_i];
endmodule

// File: rtl/iram_sfr_file.sv
// Special registers: accumulator, second operand, stack pointer and status.
// A direct write to the stack pointer overrides a same-cycle stack update.
module iram_sfr_file
    import iram_pkg::*;
#(
    parameter int unsigned BANK_LSB = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] waddr_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] raddr_i,
    output logic [7:0] rdata_o,
    input  logic       sp_upd_i,
    input  logic [7:0] sp_next_i,
    output logic [7:0] sp_o,
    output logic [1:0] bank_o
);
    logic [7:0] acc_q, b_q, sp_q, stat_q;

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            b_q    <= '0;
            sp_q   <= SP_RESET;
            stat_q <= '0;
        end else begin
            if (sp_upd_i) sp_q <= sp_next_i;
            if (we_i) begin
                case (waddr_i)
                    SFR_ACC:  acc_q  <= wdata_i;
                    SFR_B:    b_q    <= wdata_i;
                    SFR_SP:   sp_q   <= wdata_i;
                    SFR_STAT: stat_q <= wdata_i;
                    default:  ;
                endcase
            end
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        case (raddr_i)
            SFR_ACC:  rdata_o = acc_q;
            SFR_B:    rdata_o = b_q;
            SFR_SP:   rdata_o = sp_q;
            SFR_STAT: rdata_o = stat_q;
            default:  rdata_o = '0;
        endcase
    end

    assign sp_o   = sp_q;
    assign bank_o = stat_q[BANK_LSB+1:BANK_LSB];
endmodule

// File: rtl/iram_access_unit.sv
// Top of the internal data memory access unit. Resolves the operand, reads
// it combinationally and steers writes, bit merges and stack operations to
// the RAM and special-register file. Assumes one access per cycle.
module iram_access_unit
    import iram_pkg::*;
#(
    parameter int unsigned RAM_DEPTH     = 128,
    parameter int unsigned REGS_PER_BANK = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    input  logic       bit_i,
    input  logic       rd_i,
    input  logic       wr_i,
    output logic [7:0] rdata_o,
    output logic       rbit_o,
    output logic       err_ptr_o,
    output logic       err_range_o
);
    localparam int unsigned AW = $clog2(RAM_DEPTH);

    acc_mode_e     mode;
    target_t       tgt;
    logic [1:0]    bank;
    logic [7:0]    sp_q, sfr_rd, ram_a, ptr_val, stk_rd, tgt_val, merged;
    logic [AW-1:0] ptr_idx, stk_addr;
    logic          access;
    logic          ram_we, sfr_we, sp_upd;
    logic [AW-1:0] ram_waddr;
    logic [7:0]    ram_wdata, sfr_wdata, sp_next;

    assign mode   = acc_mode_e'(mode_i);
    assign access = rd_i | wr_i;

    iram_addr_resolve #(.RAM_DEPTH(RAM_DEPTH), .REGS_PER_BANK(REGS_PER_BANK)) u_resolve (
        .mode_i(mode_i), .addr_i(addr_i), .bank_i(bank), .ptr_val_i(ptr_val),
        .ptr_idx_o(ptr_idx), .tgt_o(tgt)
    );

    iram_ram #(.DEPTH(RAM_DEPTH), .DW(DW)) u_ram (
        .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
        .raddr_a_i(tgt.idx[AW-1:0]), .rdata_a_o(ram_a),
        .raddr_b_i(ptr_idx),         .rdata_b_o(ptr_val),
        .raddr_c_i(stk_addr),        .rdata_c_o(stk_rd)
    );

    iram_sfr_file u_sfr (
        .clk(clk), .rst_n(rst_n), .we_i(sfr_we), .waddr_i(tgt.idx),
        .wdata_i(sfr_wdata), .raddr_i(tgt.idx), .rdata_o(sfr_rd),
        .sp_upd_i(sp_upd), .sp_next_i(sp_next), .sp_o(sp_q), .bank_o(bank)
    );

    // Stack slot: next free slot for push, current top for pop.
    assign stk_addr = (mode == MODE_PUSH) ? AW'(sp_q + 8'd1) : AW'(sp_q);

    // Value at the resolved operand.
    assign tgt_val = tgt.to_ram ? ram_a : (tgt.to_sfr ? sfr_rd : 8'h00);

    // Byte with the addressed bit replaced.
    always_comb begin
        merged            = ram_a;
        merged[tgt.bpos]  = bit_i;
    end

    // Read outputs, gated by the read strobe.
    always_comb begin
        rdata_o = 8'h00;
        rbit_o  = 1'b0;
        if (rd_i) begin
            case (mode)
                MODE_POP: rdata_o = stk_rd;
                MODE_BIT: rbit_o  = tgt.to_ram & ram_a[tgt.bpos];
                default:  rdata_o = tgt_val;
            endcase
        end
    end

    assign err_ptr_o   = access & tgt.err_ptr;
    assign err_range_o = access & tgt.err_range;

    // Write steering for every mode.
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = tgt.idx[AW-1:0];
        ram_wdata = wdata_i;
        sfr_we    = 1'b0;
        sfr_wdata = wdata_i;
        sp_upd    = 1'b0;
        sp_next   = sp_q;
        if (wr_i) begin
            case (mode)
                MODE_REG, MODE_DIR, MODE_IND: begin
                    ram_we = tgt.to_ram;
                    sfr_we = tgt.to_sfr;
                end
                MODE_BIT: begin
                    ram_we    = tgt.to_ram;
                    ram_wdata = merged;
                end
                MODE_PUSH: begin
                    ram_we    = 1'b1;
                    ram_waddr = stk_addr;
                    ram_wdata = tgt_val;
                    sp_upd    = 1'b1;
                    sp_next   = sp_q + 8'd1;
                end
                MODE_POP: begin
                    ram_we    = tgt.to_ram;
                    sfr_we    = tgt.to_sfr;
                    ram_wdata = stk_rd;
                    sfr_wdata = stk_rd;
                    sp_upd    = 1'b1;
                    sp_next   = sp_q - 8'd1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iram_access_chk.sv
// Property checker for the access unit, attached by bind. Observes ports
// and the stack pointer register.
module iram_access_chk
    import iram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic [7:0] addr_i,
    input logic       rd_i,
    input logic       wr_i,
    input logic [7:0] rdata_o,
    input logic       rbit_o,
    input logic       err_ptr_o,
    input logic       err_range_o,
    input logic [7:0] sp_q
);
    a_r6_bad_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && mode_i == MODE_IND && addr_i[2:1] != 2'b00)
        |-> (err_ptr_o && rdata_o == 8'h00));

    a_r7_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err_range_o |-> (rdata_o == 8'h00 && !rbit_o));

    a_r9_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode_i == MODE_PUSH) |=> (sp_q == $past(sp_q) + 8'd1));

    a_r10_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode_i == MODE_POP && addr_i != SFR_SP) |=> (sp_q == $past(sp_q) - 8'd1));

    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == 8'h00 && !rbit_o));
endmodule

bind iram_access_unit iram_access_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .rdata_o(rdata_o), .rbit_o(rbit_o),
    .err_ptr_o(err_ptr_o), .err_range_o(err_range_o), .sp_q(sp_q)
);

// File: tb/tb_iram_access_unit.sv
// Scoreboard bench: driver tasks queue expected results, a monitor process
// pops and compares them against the outputs.
module tb_iram_access_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_i;
    logic [7:0] addr_i, wdata_i;
    logic       bit_i, rd_i, wr_i;
    logic [7:0] rdata_o;
    logic       rbit_o, err_ptr_o, err_range_o;

    typedef struct packed {
        logic [7:0] d;
        logic       b;
        logic       ep;
        logic       er;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  smp_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;

    iram_access_unit dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .bit_i(bit_i), .rd_i(rd_i), .wr_i(wr_i),
        .rdata_o(rdata_o), .rbit_o(rbit_o), .err_ptr_o(err_ptr_o),
        .err_range_o(err_range_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic apply(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d,
                         input logic bv, input logic r, input logic w);
        @(negedge clk);
        mode_i = m; addr_i = a; wdata_i = d; bit_i = bv; rd_i = r; wr_i = w;
    endtask

    task automatic wr_op(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d,
                         input logic bv);
        apply(m, a, d, bv, 1'b0, 1'b1);
    endtask

    task automatic rd_chk(input logic [2:0] m, input logic [7:0] a, input logic r,
                          input logic [7:0] d, input logic b, input logic ep,
                          input logic er, input string tag);
        exp_t e;
        apply(m, a, 8'h00, 1'b0, r, 1'b0);
        e.d = d; e.b = b; e.ep = ep; e.er = er;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #(CLK_PERIOD/4);
        -> smp_ev;
    endtask

    // Monitor: compare sampled outputs with the head of the queue.
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(smp_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata_o !== e.d || rbit_o !== e.b || err_ptr_o !== e.ep || err_range_o !== e.er) begin
                errors++;
                $display("FAIL %s: got data=%02h bit=%0b eptr=%0b erng=%0b, expected data=%02h bit=%0b eptr=%0b erng=%0b",
                         t, rdata_o, rbit_o, err_ptr_o, err_range_o, e.d, e.b, e.ep, e.er);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode_i = 3'd0; addr_i = 8'h00; wdata_i = 8'h00; bit_i = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values
        rd_chk(3'd1, 8'hE0, 1, 8'h00, 0, 0, 0, "R1 acc reset");
        rd_chk(3'd1, 8'hF0, 1, 8'h00, 0, 0, 0, "R1 b reset");
        rd_chk(3'd1, 8'h81, 1, 8'h07, 0, 0, 0, "R1 sp reset");
        rd_chk(3'd1, 8'hD0, 1, 8'h00, 0, 0, 0, "R1 status reset");

        // R2 R3 register/direct aliasing, bank switching
        wr_op(3'd0, 8'h04, 8'h5A, 0);
        rd_chk(3'd1, 8'h04, 1, 8'h5A, 0, 0, 0, "R3 R4 bank0 is byte 04h");
        wr_op(3'd1, 8'hD0, 8'h08, 0);
        wr_op(3'd0, 8'h04, 8'h33, 0);
        rd_chk(3'd1, 8'h0C, 1, 8'h33, 0, 0, 0, "R2 R4 bank1 is byte 0Ch");
        rd_chk(3'd1, 8'h04, 1, 8'h5A, 0, 0, 0, "R2 bank0 byte untouched");
        rd_chk(3'd0, 8'h04, 1, 8'h33, 0, 0, 0, "R2 register read bank1");

        // R4 special registers
        wr_op(3'd1, 8'hE0, 8'h11, 0);
        wr_op(3'd1, 8'hF0, 8'h22, 0);
        rd_chk(3'd1, 8'hE0, 1, 8'h11, 0, 0, 0, "R4 acc write");
        rd_chk(3'd1, 8'hF0, 1, 8'h22, 0, 0, 0, "R4 b write");
        wr_op(3'd1, 8'h90, 8'hFF, 0);
        rd_chk(3'd1, 8'h90, 1, 8'h00, 0, 0, 0, "R4 unmapped reads zero");
        rd_chk(3'd1, 8'hE0, 1, 8'h11, 0, 0, 0, "R4 unmapped write no effect");

        // R5 indirect through R0 of bank1
        wr_op(3'd0, 8'h00, 8'h40, 0);
        wr_op(3'd2, 8'h00, 8'h77, 0);
        rd_chk(3'd1, 8'h40, 1, 8'h77, 0, 0, 0, "R5 indirect write");
        rd_chk(3'd2, 8'h00, 1, 8'h77, 0, 0, 0, "R5 indirect read");

        // R6 illegal pointer register
        wr_op(3'd0, 8'h03, 8'h45, 0);
        wr_op(3'd1, 8'h45, 8'h01, 0);
        rd_chk(3'd2, 8'h03, 1, 8'h00, 0, 1, 0, "R6 R3 pointer rejected");
        wr_op(3'd2, 8'h03, 8'h99, 0);
        rd_chk(3'd1, 8'h45, 1, 8'h01, 0, 0, 0, "R6 rejected write ignored");

        // R7 out-of-range pointer
        wr_op(3'd0, 8'h01, 8'hE0, 0);
        rd_chk(3'd2, 8'h01, 1, 8'h00, 0, 0, 1, "R7 pointer E0h flagged");
        wr_op(3'd2, 8'h01, 8'h55, 0);
        rd_chk(3'd1, 8'hE0, 1, 8'h11, 0, 0, 0, "R7 acc untouched");

        // R8 bit access
        wr_op(3'd1, 8'h25, 8'h0F, 0);
        wr_op(3'd3, 8'h2E, 8'h00, 1);
        rd_chk(3'd1, 8'h25, 1, 8'h4F, 0, 0, 0, "R8 set bit 6 of 25h");
        wr_op(3'd3, 8'h29, 8'h00, 0);
        rd_chk(3'd1, 8'h25, 1, 8'h4D, 0, 0, 0, "R8 clear bit 1 of 25h");
        rd_chk(3'd3, 8'h2E, 1, 8'h00, 1, 0, 0, "R8 read bit 2Eh");
        rd_chk(3'd3, 8'h29, 1, 8'h00, 0, 0, 0, "R8 read bit 29h");
        rd_chk(3'd3, 8'h90, 1, 8'h00, 0, 0, 1, "R8 bit address range");

        // R9 push
        wr_op(3'd4, 8'hE0, 8'h00, 0);
        rd_chk(3'd1, 8'h81, 1, 8'h08, 0, 0, 0, "R9 sp after push");
        rd_chk(3'd1, 8'h08, 1, 8'h11, 0, 0, 0, "R9 pushed acc");
        wr_op(3'd4, 8'hF0, 8'h00, 0);
        rd_chk(3'd1, 8'h09, 1, 8'h22, 0, 0, 0, "R9 pushed b");

        // R10 pop
        rd_chk(3'd5, 8'h50, 1, 8'h22, 0, 0, 0, "R10 top of stack visible");
        wr_op(3'd5, 8'h50, 8'h00, 0);
        rd_chk(3'd1, 8'h50, 1, 8'h22, 0, 0, 0, "R10 popped value");
        rd_chk(3'd1, 8'h81, 1, 8'h08, 0, 0, 0, "R10 sp after pop");

        // R11 read strobe low
        rd_chk(3'd1, 8'hE0, 0, 8'h00, 0, 0, 0, "R11 no read strobe");
        rd_chk(3'd3, 8'h2E, 0, 8'h00, 0, 0, 0, "R11 no bit read strobe");

        apply(3'd0, 8'h00, 8'h00, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule